// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a local controller a small register window through which it can reach a configuration space that is addressed as an index port and a data port. Software picks the port with a select register. For a write it loads a data register, and it sets a map-enable bit. It then writes the control register with the start bit set and the direction bit chosen. The bridge then runs exactly one request/acknowledge transaction on its configuration-side interface. A write sends the data register's byte. A read captures the returned byte into the data register. Two busy flags report progress, one for reads and one for writes. After the acknowledge, a programmable hold of one to four cycles elapses before the bridge returns to idle.

The control is a three-state machine. IDLE waits for a start. IDLE→ISSUE is taken on a control write with bit 0 set, provided map-enable is set and the host power-good input is high. ISSUE holds the request. ISSUE→HOLD is taken on acknowledge and loads the hold counter. HOLD→IDLE is taken when the counter reaches zero. A start that is refused because the bridge is busy or host power is off raises a sticky error flag.

Top module: `icb_bridge`

## Requirements
- R1: After reset every register reads 0, `cfg_req` is low and both busy flags are clear.
- R2: A control write (address 3) with bit 0 set, while idle with map-enable (address 2 bit 0) set and `host_pwr_ok` high, raises `cfg_req` and the busy flag on the next cycle. The busy flag is control bit 1 when write bit 1 = 1 (read) and control bit 2 when bit 1 = 0 (write).
- R3: During a write transaction, `cfg_we` = 1, `cfg_port` equals select register bit 0 (address 0; 0 = index, 1 = data) and `cfg_wdata` equals the data register (address 1). All three, with `cfg_req`, hold steady until `cfg_ack`.
- R4: During a read transaction, `cfg_we` = 0. The `cfg_rdata` byte present with `cfg_ack` is readable at address 1 from the cycle after the acknowledge.
- R5: After the acknowledge, `cfg_req` drops at once. The busy flag stays set for W+1 cycles, where W is control bits 5:4 as written with the start.
- R6: A start written while map-enable is 0 issues no transaction and raises no error. The start bit still reads back as 1.
- R7: A start written while `host_pwr_ok` is low issues no transaction and sets the error flag (control bit 3).
- R8: A control write while busy changes no control field. If it has bit 0 set, it sets the error flag and starts nothing.
- R9: Writes to the select and data registers while busy are ignored.
- R10: Writing control with bit 3 set while idle clears the error flag.
- R11: Clearing the start bit and map-enable after completion issues no further transaction.
- R12: Control readback places start at bit 0, read-busy at bit 1, write-busy at bit 2, error at bit 3, the hold field at bits 5:4 and the stored direction at bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_pwr_ok | input | 1 | Host power-good; low blocks new transactions |
| reg_wr | input | 1 | Register write strobe from the local controller |
| reg_addr | input | 2 | Register address (0 select, 1 data, 2 map-enable, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| cfg_req | output | 1 | Configuration-side request, held until acknowledge |
| cfg_we | output | 1 | 1 for a write transaction |
| cfg_port | output | 1 | 0 index port, 1 data port |
| cfg_wdata | output | 8 | Write byte |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 8 | Read byte, valid with `cfg_ack` |

## Verification
The request and the busy flag are due one cycle after the starting control write. The captured read byte is due one cycle after the acknowledge, and the busy flag falls exactly W+1 cycles after it. The bench drives every input on a falling edge and samples at the following falling edge, so each result is examined in the first half-cycle after the rising edge that should produce it. Refused starts are checked on the cycle after the write: the request must be low and the error bit must show the expected value. Writes made while busy are checked after completion by reading the registers back.

// File: rtl/icb_pkg.sv
package icb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } icb_state_e;

    localparam int ADDR_W = 2;
    localparam int WAIT_W = 2;

    localparam logic [ADDR_W-1:0] A_SEL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_MAP  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_RD    = 1;
    localparam int CB_WBUSY = 2;
    localparam int CB_ERR   = 3;
    localparam int CB_WAIT  = 4;
    localparam int CB_DIR   = CB_WAIT + WAIT_W;
endpackage

// File: rtl/icb_regs.sv
module icb_regs
    import icb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              rbusy,
    input  logic              wbusy,
    input  logic              err_set,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic              start_pulse,
    output logic              sel_q,
    output logic [DATA_W-1:0] data_q,
    output logic              map_q,
    output logic [DATA_W-1:0] reg_rdata
);
    logic              start_q;
    logic              dir_q;
    logic              err_q;
    logic [WAIT_W-1:0] wait_q;
    logic              wr_sel, wr_data, wr_map, wr_ctrl;

    always_comb begin
        wr_sel      = reg_wr && (reg_addr == A_SEL);
        wr_data     = reg_wr && (reg_addr == A_DATA);
        wr_map      = reg_wr && (reg_addr == A_MAP);
        wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
        start_pulse = wr_ctrl && reg_wdata[CB_START];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            data_q  <= '0;
            map_q   <= 1'b0;
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
            wait_q  <= '0;
        end else begin
            if (cap_en)
                data_q <= cap_data;
            else if (wr_data && !busy)
                data_q <= reg_wdata;
            if (wr_sel && !busy)
                sel_q <= reg_wdata[0];
            if (wr_map)
                map_q <= reg_wdata[0];
            if (wr_ctrl && !busy) begin
                start_q <= reg_wdata[CB_START];
                dir_q   <= reg_wdata[CB_RD];
                wait_q  <= reg_wdata[CB_WAIT +: WAIT_W];
            end
            if (err_set)
                err_q <= 1'b1;
            else if (wr_ctrl && !busy && reg_wdata[CB_ERR])
                err_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_SEL:  reg_rdata[0] = sel_q;
            A_DATA: reg_rdata    = data_q;
            A_MAP:  reg_rdata[0] = map_q;
            A_CTRL: begin
                reg_rdata[CB_START]            = start_q;
                reg_rdata[CB_RD]               = rbusy;
                reg_rdata[CB_WBUSY]            = wbusy;
                reg_rdata[CB_ERR]              = err_q;
                reg_rdata[CB_WAIT +: WAIT_W]   = wait_q;
                reg_rdata[CB_DIR]              = dir_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R9
    data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cap_en) |=> ($stable(data_q) && $stable(sel_q)));
endmodule

// File: rtl/icb_fsm.sv
module icb_fsm
    import icb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              req_rd,
    input  logic [WAIT_W-1:0] req_wait,
    input  logic              map_en,
    input  logic              host_pwr_ok,
    input  logic              cfg_ack,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic              busy,
    output logic              rbusy,
    output logic              wbusy,
    output logic              err_set,
    output logic              cap_en
);
    icb_state_e        state_q, state_d;
    logic              rd_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              accept;

    always_comb begin
        accept  = start_pulse && (state_q == ST_IDLE) && map_en && host_pwr_ok;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (cfg_ack) state_d = ST_HOLD;
            ST_HOLD:  if (cnt_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                rd_q <= req_rd;
            if (accept)
                cnt_q <= req_wait;
            else if (state_q == ST_HOLD && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        rbusy   = busy && rd_q;
        wbusy   = busy && !rd_q;
        cfg_req = (state_q == ST_ISSUE);
        cfg_we  = cfg_req && !rd_q;
        cap_en  = cfg_req && cfg_ack && rd_q;
        err_set = start_pulse && (busy || !host_pwr_ok);
    end

    // R2
    pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> $past(host_pwr_ok && map_en && start_pulse));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req);
    // R2
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rbusy && wbusy) && (!cfg_req || rbusy || wbusy));
    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cnt_q != '0) |=> (state_q == ST_HOLD && !cfg_req));
endmodule

// File: rtl/icb_bridge.sv
module icb_bridge
    import icb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_pwr_ok,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic              cfg_port,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_ack,
    input  logic [DATA_W-1:0] cfg_rdata
);
    logic start_pulse, sel_q, map_q;
    logic busy, rbusy, wbusy, err_set, cap_en;
    logic [DATA_W-1:0] data_q;

    icb_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .rbusy      (rbusy),
        .wbusy      (wbusy),
        .err_set    (err_set),
        .cap_en     (cap_en),
        .cap_data   (cfg_rdata),
        .start_pulse(start_pulse),
        .sel_q      (sel_q),
        .data_q     (data_q),
        .map_q      (map_q),
        .reg_rdata  (reg_rdata)
    );

    icb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_pulse),
        .req_rd     (reg_wdata[CB_RD]),
        .req_wait   (reg_wdata[CB_WAIT +: WAIT_W]),
        .map_en     (map_q),
        .host_pwr_ok(host_pwr_ok),
        .cfg_ack    (cfg_ack),
        .cfg_req    (cfg_req),
        .cfg_we     (cfg_we),
        .busy       (busy),
        .rbusy      (rbusy),
        .wbusy      (wbusy),
        .err_set    (err_set),
        .cap_en     (cap_en)
    );

    assign cfg_port  = sel_q;
    assign cfg_wdata = data_q;

    // R3
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> ($stable(cfg_wdata) && $stable(cfg_port) && $stable(cfg_we)));
endmodule

// File: tb/tb_icb_bridge.sv
module tb_icb_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_pwr_ok = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cfg_req, cfg_we, cfg_port;
    logic [7:0] cfg_wdata;
    logic       cfg_ack = 1'b0;
    logic [7:0] cfg_rdata = 8'd0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    icb_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_pwr_ok(host_pwr_ok),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_port(cfg_port), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] ctrl_word(input bit is_rd, input logic [1:0] w);
        return {2'b00, w, 2'b00, is_rd, 1'b1};
    endfunction

    function automatic logic [1:0] busy_bits(input bit is_rd);
        return is_rd ? 2'b01 : 2'b10;
    endfunction

    task automatic xfer(input bit is_rd, input bit sel, input logic [7:0] wd,
                        input logic [7:0] resp, input int delay, input logic [1:0] w,
                        input bit poke);
        logic [7:0] v;
        wr(2'd0, {7'd0, sel});
        wr(2'd1, wd);
        wr(2'd2, 8'd1);
        wr(2'd3, ctrl_word(is_rd, w));
        check("R2 req", cfg_req, 1'b1);
        rd(2'd3, v);
        check("R2 busy", v[2:1], busy_bits(is_rd));
        check("R12 ctrl", {v[6:3], v[0]}, {is_rd, w, 1'b0, 1'b1});
        check(is_rd ? "R4 we" : "R3 we", cfg_we, !is_rd);
        check("R3 port", cfg_port, sel);
        if (!is_rd) check("R3 wdata", cfg_wdata, wd);
        if (poke) begin
            wr(2'd3, 8'h31);
            wr(2'd1, ~wd);
            wr(2'd0, {7'd0, !sel});
            rd(2'd3, v);
            check("R8 err", v[3], 1'b1);
            check("R8 fields", {v[6], v[5:4], v[0]}, {is_rd, w, 1'b1});
            check("R9 port", cfg_port, sel);
            check("R8 req", cfg_req, 1'b1);
        end
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            check("R3 hold", {cfg_req, cfg_port}, {1'b1, sel});
            if (!is_rd) check("R3 wdata hold", cfg_wdata, wd);
        end
        cfg_ack = 1'b1; cfg_rdata = resp;
        @(negedge clk);
        cfg_ack = 1'b0; cfg_rdata = 8'h00;
        check("R5 req drop", cfg_req, 1'b0);
        for (int j = 0; j <= int'(w); j++) begin
            rd(2'd3, v);
            check("R5 busy held", v[2:1], busy_bits(is_rd));
            @(negedge clk);
        end
        rd(2'd3, v);
        check("R5 busy clear", v[2:1], 2'b00);
        rd(2'd1, v);
        if (is_rd) check("R4 capture", v, resp);
        else       check("R9 data kept", v, wd);
        rd(2'd0, v);
        check("R9 sel kept", v[0], sel);
        wr(2'd3, 8'h08);
        wr(2'd2, 8'h00);
        rd(2'd3, v);
        check("R10 err clear", v[3], 1'b0);
        for (int k = 0; k < 3; k++) begin
            check("R11 no req", cfg_req, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reg reset", v, 8'h00);
        end
        check("R1 req reset", cfg_req, 1'b0);

        // map-enable clear: no transaction, no error
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        check("R6 no req", cfg_req, 1'b0);
        rd(2'd3, v);
        check("R6 start kept", v[0], 1'b1);
        check("R6 no err", v[3:1], 3'b000);
        wr(2'd3, 8'h00);

        // host power low: no transaction, error set
        host_pwr_ok = 1'b0;
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h01);
        check("R7 no req", cfg_req, 1'b0);
        rd(2'd3, v);
        check("R7 err", v[3], 1'b1);
        check("R7 not busy", v[2:1], 2'b00);
        host_pwr_ok = 1'b1;
        wr(2'd3, 8'h08);
        rd(2'd3, v);
        check("R10 err clear", v[3], 1'b0);
        wr(2'd2, 8'h00);

        // directed corners
        xfer(1'b0, 1'b0, 8'h5A, 8'h00, 0, 2'd0, 1'b0);
        xfer(1'b1, 1'b1, 8'h00, 8'hC3, 0, 2'd3, 1'b0);
        xfer(1'b0, 1'b1, 8'hA5, 8'h00, 4, 2'd2, 1'b1);
        xfer(1'b1, 1'b0, 8'h11, 8'h7E, 2, 2'd1, 1'b1);

        // random mix
        for (int n = 0; n < 40; n++) begin
            xfer(bit'($urandom % 2), bit'($urandom % 2), 8'($urandom), 8'($urandom),
                 int'($urandom % 5), 2'($urandom % 4), 1'b0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule